// File: doc/BRIEF.md
# Push-Button Power Sequencing Controller

This block is a synchronous state machine that brings up and tears down the supply rails of a processor system. A press of the power button turns on the main rail alone. Once that rail reports it is near its target, two auxiliary rails come on and the processor is held in reset for a programmable number of clock ticks. Reset is released only if the main rail is inside its regulation window when that period ends. From then on, the processor keeps the system alive by driving any of its three hold lines. Each hold line gates one of the first three rails, and the two auxiliary rails follow enable bits supplied from a register bank. If the button is let go before the processor has taken over, everything shuts down on its own. This protects against short, accidental presses.

An over-temperature flag removes every rail at once. The machine then stays off until a separate release flag reports that the die has cooled by the hysteresis amount. A hard press, with the button pin tied straight to ground, pulls the processor reset low again and restarts the reset period. An active-low interrupt is raised on each start-up and on the rising edge of any fault that is unmasked. It holds until the register interface pulses a poll strobe. Comparators, pads, the register slave and button debouncing all sit outside the block and arrive here as clean digital levels.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge all rail enables are 0, `rst_out_n` is 0 and `irq_n` is 1.
- R2: From the off state with no over-temperature, `btn_n` low at an edge makes `rail_en` equal to 5'b00001 (bit 0 = main rail only) and drives `irq_n` low after that edge.
- R3: While only the main rail is on, `pgood_94` high at an edge switches `rail_en` to 5'b11001 (main rail plus auxiliary rails on bits 3 and 4), with `rst_out_n` still low.
- R4: If the edge that sees `pgood_94` is edge E, then `rst_out_n` rises after edge E+RST_TICKS+1 when `in_reg` is high from then on. If `in_reg` is low at that point, `rst_out_n` stays low until the first edge at which `in_reg` is high.
- R5: Before the processor has taken over, `btn_n` high together with all hold lines low at an edge turns every rail off after that edge.
- R6: With reset released and at least one hold line high, the block enters the running state at the next edge. There, `rail_en[2:0]` equals `hold[2:0]` and `rail_en[4:3]` equals `aux_en[1:0]`, and releasing the button has no effect.
- R7: In the running state, all three hold lines low at an edge turn every rail off and drive `rst_out_n` low after that edge.
- R8: `ot_trip` high at an edge turns every rail off and drives `rst_out_n` low, and `ot_trip` also gates all rail enables to 0 in the same cycle. The rails stay off after `ot_trip` falls until an edge sees `ot_clear` high. The block then returns to the off state, from which a press restarts it.
- R9: `btn_gnd` high at an edge in the sequencing or running state drives `rst_out_n` low after that edge and restarts the reset period (release as in R4), leaving the rail enables unchanged.
- R10: A bit of `fault_in` rising while the matching bit of `fault_unmask` is 1 drives `irq_n` low after that edge. Masked bits, and bits that stay high, raise nothing.
- R11: `irq_n` stays low until an edge sees `irq_ack` high, and then returns to 1. If a new set event falls on the same edge as `irq_ack`, the set wins and `irq_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_n | input | 1 | Debounced push-button level, low while pressed |
| btn_gnd | input | 1 | High when the button pin is tied hard to ground |
| hold | input | 3 | Processor hold lines, one per rail 0..2 |
| pgood_94 | input | 1 | Main rail has reached 94% of target |
| in_reg | input | 1 | Main rail is inside its regulation window |
| ot_trip | input | 1 | Die over-temperature |
| ot_clear | input | 1 | Die has cooled by the hysteresis amount |
| aux_en | input | 2 | Register enables for auxiliary rails 3 and 4 |
| fault_in | input | NUM_FAULTS | Fault condition levels |
| fault_unmask | input | NUM_FAULTS | 1 lets the matching fault raise the interrupt |
| irq_ack | input | 1 | Poll strobe that clears the interrupt |
| rail_en | output | 5 | Rail enables, bit 0 main rail, bits 3..4 auxiliary |
| rst_out_n | output | 1 | Active-low processor reset |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The interrupt latch has two sources, a start-up or fault-edge set and the poll-strobe clear, and both can land on the same edge. The bench drops a fault to 0 for one cycle. It then raises the fault again, with its mask bit open, in the same cycle as `irq_ack`, and expects `irq_n` to stay low after that edge. The next lone strobe must then release it. The hard-ground restart is also provoked while the machine is running. This checks that the reset period starts again and the rails are not disturbed.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding and rail layout for the power sequencer.
// Assumes five rails: three gated by hold lines, two driven by register bits.
package pwr_seq_pkg;

    localparam int HOLD_W    = 3;
    localparam int AUX_W     = 2;
    localparam int RAIL_W    = HOLD_W + AUX_W;
    localparam int RAIL_MAIN = 0;
    localparam int RAIL_AUX0 = HOLD_W;
    localparam int RAIL_AUX1 = HOLD_W + 1;

    typedef enum logic [2:0] {
        ST_OFF = 3'd0,  // everything off, waiting for a press
        ST_PRI = 3'd1,  // main rail ramping
        ST_SEQ = 3'd2,  // aux rails on, reset period running
        ST_RUN = 3'd3,  // processor owns the rails through hold lines
        ST_HOT = 3'd4   // thermal lockout
    } seq_st_t;

endpackage

// File: rtl/pwr_seq_fsm.sv
`timescale 1ns/1ps
// Module: sequencing state machine.
// Decides the next state from the button, hold lines, rail flags and the
// thermal flags. Emits a pulse that restarts the reset timer and a pulse
// that marks a start-up for the interrupt logic.
// Assumes all inputs are synchronous to clk.
module pwr_seq_fsm
    import pwr_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_n,
    input  logic              btn_gnd,
    input  logic [HOLD_W-1:0] hold,
    input  logic              pgood_94,
    input  logic              rst_rel,
    input  logic              ot_trip,
    input  logic              ot_clear,
    output seq_st_t           st,
    output seq_st_t           st_nxt,
    output logic              tmr_start,
    output logic              startup_evt
);

    logic any_hold;
    logic abort;
    logic nxt_live;
    logic cur_live;

    assign any_hold = |hold;
    assign abort    = btn_n && !any_hold;

    // Next-state decision; thermal trip outranks every other cause.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_OFF: begin
                if (ot_trip)     st_nxt = ST_HOT;
                else if (!btn_n) st_nxt = ST_PRI;
            end
            ST_PRI: begin
                if (ot_trip)       st_nxt = ST_HOT;
                else if (abort)    st_nxt = ST_OFF;
                else if (pgood_94) st_nxt = ST_SEQ;
            end
            ST_SEQ: begin
                if (ot_trip)                  st_nxt = ST_HOT;
                else if (abort)               st_nxt = ST_OFF;
                else if (rst_rel && any_hold) st_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (ot_trip)        st_nxt = ST_HOT;
                else if (!any_hold) st_nxt = ST_OFF;
            end
            ST_HOT: begin
                if (ot_clear && !ot_trip) st_nxt = ST_OFF;
            end
            default: st_nxt = ST_OFF;
        endcase
    end

    // Whether the current and next states keep the processor powered.
    assign cur_live = (st == ST_SEQ) || (st == ST_RUN);
    assign nxt_live = (st_nxt == ST_SEQ) || (st_nxt == ST_RUN);

    // Timer restarts on entry to sequencing or on a hard press while live.
    assign tmr_start = ((st == ST_PRI) && (st_nxt == ST_SEQ)) ||
                       (btn_gnd && cur_live && nxt_live);

    // A start-up is the step out of the off state into main-rail ramp.
    assign startup_evt = (st == ST_OFF) && (st_nxt == ST_PRI);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_nxt;
    end

endmodule

// File: rtl/pwr_seq_rst_timer.sv
`timescale 1ns/1ps
// Module: processor reset timer.
// A down-counter loaded with RST_TICKS on each restart pulse. When it is
// empty and the main rail is in its window, the release flag is set. The
// flag is cleared on a restart and whenever the next state is not powered.
// Assumes restart is a single-cycle pulse from the state machine.
module pwr_seq_rst_timer
    import pwr_seq_pkg::*;
#(
    parameter int RST_TICKS = 26_000_000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  seq_st_t st_nxt,
    input  logic    in_reg,
    output logic    rst_rel
);

    localparam int CW = $clog2(RST_TICKS + 1);

    logic [CW-1:0] cnt;
    logic          live;
    logic          expired;

    assign live    = (st_nxt == ST_SEQ) || (st_nxt == ST_RUN);
    assign expired = (cnt == '0);

    // Counter load and decrement, plus the qualified release flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            rst_rel <= 1'b0;
        end else if (start) begin
            cnt     <= CW'(RST_TICKS);
            rst_rel <= 1'b0;
        end else begin
            if (!expired) cnt <= cnt - 1'b1;
            if (!live)                  rst_rel <= 1'b0;
            else if (expired && in_reg) rst_rel <= 1'b1;
        end
    end

endmodule

// File: rtl/pwr_seq_irq.sv
`timescale 1ns/1ps
// Module: interrupt latch.
// Set by a start-up pulse or by the rising edge of any unmasked fault.
// Cleared by the poll strobe. A set event on the same edge wins.
// Assumes the fault bits are synchronous levels.
module pwr_seq_irq #(
    parameter int NUM_FAULTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  startup_evt,
    input  logic [NUM_FAULTS-1:0] fault_in,
    input  logic [NUM_FAULTS-1:0] fault_unmask,
    input  logic                  irq_ack,
    output logic                  irq_q
);

    logic [NUM_FAULTS-1:0] fault_q;
    logic [NUM_FAULTS-1:0] rise;
    logic                  set_evt;

    // Per-bit rising-edge detect gated by the mask.
    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_edge
        assign rise[i] = fault_in[i] && !fault_q[i] && fault_unmask[i];
    end

    assign set_evt = startup_evt || (|rise);

    // Previous fault levels and the latch itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            fault_q <= fault_in;
            if (set_evt)      irq_q <= 1'b1;
            else if (irq_ack) irq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
// Module: push-button power sequencing controller (top).
// Connects the state machine, the reset timer and the interrupt latch, and
// decodes the rail enables from the state. An over-temperature flag masks
// the rail enables in the same cycle. Assumes debounced synchronous inputs.
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int RST_TICKS  = 26_000_000,
    parameter int NUM_FAULTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  btn_n,
    input  logic                  btn_gnd,
    input  logic [2:0]            hold,
    input  logic                  pgood_94,
    input  logic                  in_reg,
    input  logic                  ot_trip,
    input  logic                  ot_clear,
    input  logic [1:0]            aux_en,
    input  logic [NUM_FAULTS-1:0] fault_in,
    input  logic [NUM_FAULTS-1:0] fault_unmask,
    input  logic                  irq_ack,
    output logic [4:0]            rail_en,
    output logic                  rst_out_n,
    output logic                  irq_n
);

    seq_st_t st;
    seq_st_t st_nxt;
    logic    tmr_start;
    logic    startup_evt;
    logic    rst_rel;
    logic    irq_q;
    logic [RAIL_W-1:0] rail_dec;

    pwr_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .btn_n       (btn_n),
        .btn_gnd     (btn_gnd),
        .hold        (hold),
        .pgood_94    (pgood_94),
        .rst_rel     (rst_rel),
        .ot_trip     (ot_trip),
        .ot_clear    (ot_clear),
        .st          (st),
        .st_nxt      (st_nxt),
        .tmr_start   (tmr_start),
        .startup_evt (startup_evt)
    );

    pwr_seq_rst_timer #(
        .RST_TICKS (RST_TICKS)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .st_nxt  (st_nxt),
        .in_reg  (in_reg),
        .rst_rel (rst_rel)
    );

    pwr_seq_irq #(
        .NUM_FAULTS (NUM_FAULTS)
    ) u_irq (
        .clk          (clk),
        .rst_n        (rst_n),
        .startup_evt  (startup_evt),
        .fault_in     (fault_in),
        .fault_unmask (fault_unmask),
        .irq_ack      (irq_ack),
        .irq_q        (irq_q)
    );

    // Rail enable decode from the state, overridden by a thermal trip.
    always_comb begin
        rail_dec = '0;
        unique case (st)
            ST_PRI: rail_dec[RAIL_MAIN] = 1'b1;
            ST_SEQ: begin
                rail_dec[RAIL_MAIN] = 1'b1;
                rail_dec[RAIL_AUX0] = 1'b1;
                rail_dec[RAIL_AUX1] = 1'b1;
            end
            ST_RUN: rail_dec = {aux_en, hold};
            default: rail_dec = '0;
        endcase
        if (ot_trip) rail_dec = '0;
    end

    assign rail_en   = rail_dec;
    assign rst_out_n = rst_rel;
    assign irq_n     = !irq_q;

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for pwr_seq_ctrl, attached by bind.
// Observes ports and the state register of the top.
module pwr_seq_ctrl_chk
    import pwr_seq_pkg::*;
#(
    parameter int NUM_FAULTS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  btn_n,
    input logic                  btn_gnd,
    input logic [2:0]            hold,
    input logic                  pgood_94,
    input logic                  ot_trip,
    input logic [NUM_FAULTS-1:0] fault_in,
    input logic [NUM_FAULTS-1:0] fault_unmask,
    input logic                  irq_ack,
    input logic [4:0]            rail_en,
    input logic                  rst_out_n,
    input logic                  irq_n,
    input seq_st_t               st
);

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (rail_en == '0 && !rst_out_n && irq_n));

    p_press_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF && !btn_n && !ot_trip)
        |=> ((ot_trip || rail_en == 5'b00001) && !irq_n));

    p_aux_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PRI && pgood_94 && !ot_trip && !(btn_n && hold == '0))
        |=> ((ot_trip || rail_en == 5'b11001) && !rst_out_n));

    p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PRI || st == ST_SEQ) && btn_n && hold == '0 && !ot_trip)
        |=> (rail_en == '0));

    p_take_over_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEQ && rst_out_n && hold != '0 && !ot_trip && !btn_gnd)
        |=> (st == ST_RUN && rst_out_n));

    p_release_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && hold == '0 && !ot_trip)
        |=> (rail_en == '0 && !rst_out_n));

    p_thermal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ot_trip |=> (rail_en == '0 && !rst_out_n));

    p_hard_press_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_gnd && st == ST_RUN && hold != '0 && !ot_trip) |=> !rst_out_n);

    p_fault_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fault_in & ~$past(fault_in) & fault_unmask)) |=> !irq_n);

    p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !irq_ack) |=> !irq_n);

endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(
    .NUM_FAULTS (NUM_FAULTS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .btn_n        (btn_n),
    .btn_gnd      (btn_gnd),
    .hold         (hold),
    .pgood_94     (pgood_94),
    .ot_trip      (ot_trip),
    .fault_in     (fault_in),
    .fault_unmask (fault_unmask),
    .irq_ack      (irq_ack),
    .rail_en      (rail_en),
    .rst_out_n    (rst_out_n),
    .irq_n        (irq_n),
    .st           (st)
);

// File: tb/pwr_seq_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected output triples tagged with a
// target cycle; the monitor pops and compares them 1 ns after each rising edge.
module pwr_seq_ctrl_bench;

    localparam int N  = 8;
    localparam int NF = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          btn_n = 1'b1;
    logic          btn_gnd = 1'b0;
    logic [2:0]    hold = '0;
    logic          pgood_94 = 1'b0;
    logic          in_reg = 1'b0;
    logic          ot_trip = 1'b0;
    logic          ot_clear = 1'b0;
    logic [1:0]    aux_en = '0;
    logic [NF-1:0] fault_in = '0;
    logic [NF-1:0] fault_unmask = '0;
    logic          irq_ack = 1'b0;
    logic [4:0]    rail_en;
    logic          rst_out_n;
    logic          irq_n;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [4:0] rails;
        logic       rstn;
        logic       irqn;
        string      tag;
    } exp_t;

    exp_t q[$];

    pwr_seq_ctrl #(.RST_TICKS(N), .NUM_FAULTS(NF)) u_pwr_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .btn_gnd(btn_gnd),
        .hold(hold), .pgood_94(pgood_94), .in_reg(in_reg),
        .ot_trip(ot_trip), .ot_clear(ot_clear), .aux_en(aux_en),
        .fault_in(fault_in), .fault_unmask(fault_unmask),
        .irq_ack(irq_ack), .rail_en(rail_en), .rst_out_n(rst_out_n),
        .irq_n(irq_n)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every due expectation just after the edge.
    always begin
        @(posedge clk);
        #1;
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (rail_en !== e.rails || rst_out_n !== e.rstn || irq_n !== e.irqn) begin
                fails++;
                $display("FAIL %s: got rails=%b rst_n=%b irq_n=%b expected rails=%b rst_n=%b irq_n=%b",
                         e.tag, rail_en, rst_out_n, irq_n, e.rails, e.rstn, e.irqn);
            end
        end
    end

    task automatic expect_at(input int d, input logic [4:0] r, input logic rn,
                             input logic in, input string tag);
        exp_t e;
        e.at = cyc + d; e.rails = r; e.rstn = rn; e.irqn = in; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    // Driver.
    initial begin
        step(2);
        expect_at(1, 5'b00000, 1'b0, 1'b1, "R1 reset state");
        step(1);
        rst_n = 1'b1;
        expect_at(1, 5'b00000, 1'b0, 1'b1, "R1 idle after reset");
        step(1);

        // Start-up and interrupt from start-up.
        btn_n = 1'b0;
        expect_at(1, 5'b00001, 1'b0, 1'b0, "R2 main rail only");
        step(1);
        irq_ack = 1'b1;
        expect_at(1, 5'b00001, 1'b0, 1'b1, "R11 poll clears");
        step(1);
        irq_ack = 1'b0;
        step(2);
        pgood_94 = 1'b1; in_reg = 1'b1;
        expect_at(1, 5'b11001, 1'b0, 1'b1, "R3 aux rails on");
        expect_at(N + 1, 5'b11001, 1'b0, 1'b1, "R4 reset held to period end");
        expect_at(N + 2, 5'b11001, 1'b1, 1'b1, "R4 reset released");
        step(N + 2);

        // Processor takes over.
        hold = 3'b010; aux_en = 2'b01;
        expect_at(1, 5'b01010, 1'b1, 1'b1, "R6 running rails");
        step(1);
        btn_n = 1'b1;
        expect_at(1, 5'b01010, 1'b1, 1'b1, "R6 button release ignored");
        step(1);
        hold = 3'b101; aux_en = 2'b10;
        expect_at(1, 5'b10101, 1'b1, 1'b1, "R6 rails follow hold and aux");
        step(1);

        // Hard press while running.
        btn_gnd = 1'b1;
        expect_at(1, 5'b10101, 1'b0, 1'b1, "R9 reset reasserted");
        expect_at(N + 1, 5'b10101, 1'b0, 1'b1, "R9 reset held");
        expect_at(N + 2, 5'b10101, 1'b1, 1'b1, "R9 reset released again");
        step(1);
        btn_gnd = 1'b0;
        step(N + 1);

        // Fault interrupts.
        fault_unmask = 4'b0010; fault_in = 4'b0001;
        expect_at(1, 5'b10101, 1'b1, 1'b1, "R10 masked fault ignored");
        step(1);
        fault_in = 4'b0011;
        expect_at(1, 5'b10101, 1'b1, 1'b0, "R10 unmasked rise");
        step(1);
        irq_ack = 1'b1;
        expect_at(1, 5'b10101, 1'b1, 1'b1, "R11 poll clears with level held");
        step(1);
        irq_ack = 1'b0;
        step(1);
        expect_at(1, 5'b10101, 1'b1, 1'b1, "R10 held level no retrigger");
        step(1);
        fault_in = 4'b0000;
        step(1);
        fault_in = 4'b0010; irq_ack = 1'b1;
        expect_at(1, 5'b10101, 1'b1, 1'b0, "R11 set wins over poll");
        step(1);
        irq_ack = 1'b1;
        expect_at(1, 5'b10101, 1'b1, 1'b1, "R11 lone poll clears");
        step(1);
        irq_ack = 1'b0;

        // Processor lets go.
        hold = 3'b000; pgood_94 = 1'b0; in_reg = 1'b0;
        expect_at(1, 5'b00000, 1'b0, 1'b1, "R7 shutdown on hold release");
        expect_at(2, 5'b00000, 1'b0, 1'b1, "R7 stays off");
        step(2);

        // Abort during main-rail ramp.
        btn_n = 1'b0;
        expect_at(1, 5'b00001, 1'b0, 1'b0, "R2 second start");
        step(1);
        irq_ack = 1'b1;
        expect_at(1, 5'b00001, 1'b0, 1'b1, "R11 poll clears");
        step(1);
        irq_ack = 1'b0; btn_n = 1'b1;
        expect_at(1, 5'b00000, 1'b0, 1'b1, "R5 abort while ramping");
        step(1);

        // Abort during reset period.
        btn_n = 1'b0; pgood_94 = 1'b1;
        expect_at(1, 5'b00001, 1'b0, 1'b0, "R2 third start");
        step(1);
        expect_at(1, 5'b11001, 1'b0, 1'b0, "R3 aux rails on");
        step(1);
        btn_n = 1'b1;
        expect_at(1, 5'b00000, 1'b0, 1'b0, "R5 abort during reset period");
        step(1);
        irq_ack = 1'b1;
        expect_at(1, 5'b00000, 1'b0, 1'b1, "R11 poll clears");
        step(1);
        irq_ack = 1'b0;

        // Out-of-window at period end.
        btn_n = 1'b0;
        expect_at(1, 5'b00001, 1'b0, 1'b0, "R2 fourth start");
        step(1);
        expect_at(1, 5'b11001, 1'b0, 1'b0, "R3 aux rails on");
        expect_at(N + 2, 5'b11001, 1'b0, 1'b0, "R4 held while out of window");
        step(N + 2);
        in_reg = 1'b1;
        expect_at(1, 5'b11001, 1'b1, 1'b0, "R4 late release");
        step(1);

        // Thermal lockout.
        ot_trip = 1'b1;
        expect_at(1, 5'b00000, 1'b0, 1'b0, "R8 thermal trip");
        step(1);
        ot_trip = 1'b0;
        expect_at(1, 5'b00000, 1'b0, 1'b0, "R8 locked until release flag");
        step(1);
        ot_clear = 1'b1;
        expect_at(1, 5'b00000, 1'b0, 1'b0, "R8 release to off");
        step(1);
        ot_clear = 1'b0;
        expect_at(1, 5'b00001, 1'b0, 1'b0, "R8 restart after release");
        step(1);

        btn_n = 1'b1; irq_ack = 1'b1;
        step(3);
        if (q.size() != 0) begin
            fails++;
            $display("FAIL pending: got %0d unchecked expected 0", q.size());
        end
        finish_run();
    end

endmodule